// File: doc/BRIEF.md
# DSP Status Register with Condition Bit

This block keeps the 8-bit status word of a DSP execution unit and produces the single condition bit (DC) that decides whether a conditional DSP data operation may write its destination registers. Each cycle the decode stage presents one or more operation-class strobes, and the arithmetic path presents its result flags (carry/borrow, negative, zero, overflow), all derived from the full 40-bit accumulator-width result. When the operation class is allowed to touch the flags, the register captures negative, zero, overflow and a signed greater-than bit. It also captures DC, picked from the result conditions by a 3-bit selector that lives inside the same register.

Software reaches the register through a system-register path. A load writes the low eight bits of a 32-bit word, and a load that lands in the same cycle as a flag update wins. A store returns the 8-bit value zero-extended to 32 bits. The destination write qualifier passes a write request through unchanged for every operation except a conditional DSP operation, which passes it only while DC is 1. Address-register updates and memory traffic never go through this qualifier.

Top module: `dsp_cond_status`

## Requirements
- R1: An active-low reset clears all eight status bits, so the status word, DC and the store word all read 0.
- R2: The store word is 32 bits: bits 31:8 are 0 and bits 7:0 equal the status register.
- R3: A system-register load replaces status bits 7:0 with load-word bits 7:0 on the next clock edge. Load-word bits 31:8 have no effect.
- R4: When a load and a flag-updating operation occur in the same cycle, the register takes the load value.
- R5: An unconditional data operation with no excluded class asserted updates the status bits as follows. Bit 1 takes negative, bit 2 takes zero and bit 3 takes overflow. Bit 7 takes greater-than, which is not-zero AND (negative XNOR overflow). The selector field in bits 6:4 keeps its value.
- R6: On such an update, bit 0 (DC) follows the selector in bits 6:4: 000 carry, 001 negative, 010 zero, 011 overflow, 100 greater-than, 101 negative XNOR overflow. The codes 110 and 111 clear DC.
- R7: The register holds its value when a parallel multiply, an X/Y memory move or a single-data move is asserted, even if the unconditional strobe is also high.
- R8: A CPU-side instruction, including multiply-accumulate, leaves the register unchanged.
- R9: A conditional DSP data operation leaves the register unchanged.
- R10: The destination write enable equals the write request, except during a conditional operation, when it also requires DC = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_uncond | input | 1 | Unconditional DSP data operation |
| op_cond | input | 1 | Conditional DSP data operation |
| op_pmul | input | 1 | Parallel multiply |
| op_xymove | input | 1 | X or Y memory move |
| op_smove | input | 1 | Single-data move |
| op_cpu | input | 1 | CPU-side instruction |
| res_carry | input | 1 | Carry/borrow of the result |
| res_neg | input | 1 | Negative flag of the 40-bit result |
| res_zero | input | 1 | Zero flag of the 40-bit result |
| res_ovf | input | 1 | Overflow flag of the result |
| ld_en | input | 1 | System-register load strobe |
| ld_word | input | 32 | Load data word |
| st_word | output | 32 | Store data word, zero-extended |
| status | output | 8 | Status register value |
| dc | output | 1 | Condition bit (status bit 0) |
| dst_req | input | 1 | Destination register write request |
| dst_we | output | 1 | Qualified destination write enable |

## Verification
A wrong selector decode or a missed exclusion shows up on the status and store words one clock after the offending operation, because every update is a single registered step. A corrupted DC shows up on the destination write enable in the same cycle as the next conditional operation, since that path is purely combinational from the register. The stimulus loads each selector code, drives flag combinations that separate the candidate conditions, and then checks the full 8-bit word.

// File: rtl/dsp_cond_status.sv
module dsp_cond_status #(
  parameter int SR_W   = 8,
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              op_uncond,
  input  logic              op_cond,
  input  logic              op_pmul,
  input  logic              op_xymove,
  input  logic              op_smove,
  input  logic              op_cpu,
  input  logic              res_carry,
  input  logic              res_neg,
  input  logic              res_zero,
  input  logic              res_ovf,
  input  logic              ld_en,
  input  logic [WORD_W-1:0] ld_word,
  output logic [WORD_W-1:0] st_word,
  output logic [SR_W-1:0]   status,
  output logic              dc,
  input  logic              dst_req,
  output logic              dst_we
);
  localparam int B_DC = 0;
  localparam int B_N  = 1;
  localparam int B_Z  = 2;
  localparam int B_V  = 3;
  localparam int B_CS = 4;
  localparam int B_GT = 7;
  localparam int PAD  = WORD_W - SR_W;

  logic [SR_W-1:0] sr_q, sr_upd;
  logic [2:0]      sel;
  logic            gt, ge, dc_new, upd_ok;

  assign sel    = sr_q[B_CS +: 3];
  assign ge     = ~(res_neg ^ res_ovf);
  assign gt     = ~res_zero & ge;
  assign upd_ok = op_uncond & ~op_cond & ~op_pmul & ~op_xymove & ~op_smove & ~op_cpu;

  always_comb begin
    unique case (sel)
      3'd0:    dc_new = res_carry;
      3'd1:    dc_new = res_neg;
      3'd2:    dc_new = res_zero;
      3'd3:    dc_new = res_ovf;
      3'd4:    dc_new = gt;
      3'd5:    dc_new = ge;
      default: dc_new = 1'b0;
    endcase
  end

  always_comb begin
    sr_upd       = sr_q;
    sr_upd[B_DC] = dc_new;
    sr_upd[B_N]  = res_neg;
    sr_upd[B_Z]  = res_zero;
    sr_upd[B_V]  = res_ovf;
    sr_upd[B_GT] = gt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      sr_q <= '0;
    else if (ld_en)  sr_q <= ld_word[SR_W-1:0];
    else if (upd_ok) sr_q <= sr_upd;
  end

  assign status  = sr_q;
  assign dc      = sr_q[B_DC];
  assign st_word = {{PAD{1'b0}}, sr_q};
  assign dst_we  = dst_req & (~op_cond | sr_q[B_DC]);
endmodule

module dsp_cond_status_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        op_uncond,
  input logic        op_cond,
  input logic        op_pmul,
  input logic        op_xymove,
  input logic        op_smove,
  input logic        op_cpu,
  input logic        res_carry,
  input logic        res_neg,
  input logic        res_zero,
  input logic        res_ovf,
  input logic        ld_en,
  input logic [31:0] ld_word,
  input logic [7:0]  status,
  input logic        dc,
  input logic        dst_req,
  input logic        dst_we
);
  logic excl;
  assign excl = op_pmul | op_xymove | op_smove;

  p_reset_clear_r1: assert property (@(posedge clk) !rst_n |=> status == 8'h00);

  p_load_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ld_en |=> status == $past(ld_word[7:0]));

  p_sel_keep_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !ld_en |=> status[6:4] == $past(status[6:4]));

  p_rsvd_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!ld_en && op_uncond && !op_cond && !excl && !op_cpu && status[6:5] == 2'b11) |=> !dc);

  p_excl_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!ld_en && excl) |=> $stable(status));

  p_cpu_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!ld_en && op_cpu) |=> $stable(status));

  p_cond_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!ld_en && op_cond) |=> $stable(status));

  p_cond_gate_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (op_cond && !dc) |-> !dst_we);
endmodule

bind dsp_cond_status dsp_cond_status_chk u_chk (
  .clk(clk), .rst_n(rst_n), .op_uncond(op_uncond), .op_cond(op_cond),
  .op_pmul(op_pmul), .op_xymove(op_xymove), .op_smove(op_smove), .op_cpu(op_cpu),
  .res_carry(res_carry), .res_neg(res_neg), .res_zero(res_zero), .res_ovf(res_ovf),
  .ld_en(ld_en), .ld_word(ld_word), .status(status), .dc(dc),
  .dst_req(dst_req), .dst_we(dst_we)
);

// File: tb/dsp_cond_status_bench.sv
module dsp_cond_status_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic op_uncond = 0, op_cond = 0, op_pmul = 0, op_xymove = 0, op_smove = 0, op_cpu = 0;
  logic res_carry = 0, res_neg = 0, res_zero = 0, res_ovf = 0;
  logic ld_en = 0, dst_req = 0;
  logic [31:0] ld_word = '0;
  logic [31:0] st_word;
  logic [7:0]  status;
  logic        dc, dst_we;
  int errors = 0, checks = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  dsp_cond_status u_dsp_cond_status (.*);

  // {sel[2:0], carry, neg, zero, ovf, expected status[7:0]}
  localparam logic [14:0] VEC [12] = '{
    {3'd0, 4'b1000, 8'h81}, {3'd0, 4'b0100, 8'h02},
    {3'd1, 4'b0100, 8'h13}, {3'd2, 4'b0010, 8'h25},
    {3'd3, 4'b0001, 8'h39}, {3'd4, 4'b0101, 8'hCB},
    {3'd4, 4'b0010, 8'h44}, {3'd5, 4'b1100, 8'h52},
    {3'd5, 4'b0010, 8'h55}, {3'd6, 4'b1000, 8'hE0},
    {3'd7, 4'b1101, 8'hFA}, {3'd3, 4'b1100, 8'h32}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle();
    {op_uncond, op_cond, op_pmul, op_xymove, op_smove, op_cpu} = '0;
    {res_carry, res_neg, res_zero, res_ovf} = '0;
    ld_en = 0; ld_word = '0; dst_req = 0;
  endtask

  task automatic load(input logic [31:0] w);
    ld_en = 1; ld_word = w;
    @(negedge clk);
    idle();
  endtask

  task automatic uop(input logic [3:0] f);
    op_uncond = 1; {res_carry, res_neg, res_zero, res_ovf} = f;
    @(negedge clk);
    idle();
  endtask

  initial begin
    #200000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 status", {24'h0, status}, 32'h0);
    chk("R1 store", st_word, 32'h0);
    rst_n = 1;
    @(negedge clk);

    foreach (VEC[i]) begin
      load({25'h0, VEC[i][14:12], 4'h0});
      uop(VEC[i][11:8]);
      chk($sformatf("R5/R6 vec%0d", i), {24'h0, status}, {24'h0, VEC[i][7:0]});
    end

    load(32'hABCD_EF5A);
    chk("R3 upper ignored", {24'h0, status}, 32'h5A);
    chk("R2 store word", st_word, 32'h0000_005A);

    ld_en = 1; ld_word = 32'h30; op_uncond = 1; res_zero = 1; res_carry = 1;
    @(negedge clk); idle();
    chk("R4 load wins", {24'h0, status}, 32'h30);

    op_uncond = 1; op_pmul = 1; res_zero = 1; @(negedge clk); idle();
    chk("R7 pmul hold", {24'h0, status}, 32'h30);
    op_uncond = 1; op_xymove = 1; res_neg = 1; @(negedge clk); idle();
    chk("R7 xymove hold", {24'h0, status}, 32'h30);
    op_uncond = 1; op_smove = 1; res_ovf = 1; @(negedge clk); idle();
    chk("R7 smove hold", {24'h0, status}, 32'h30);
    op_cpu = 1; op_uncond = 1; res_ovf = 1; @(negedge clk); idle();
    chk("R8 cpu hold", {24'h0, status}, 32'h30);
    op_cond = 1; op_uncond = 1; res_ovf = 1; @(negedge clk); idle();
    chk("R9 cond hold", {24'h0, status}, 32'h30);

    op_cond = 1; dst_req = 1; #1;
    chk("R10 cond dc=0", {31'h0, dst_we}, 32'h0);
    idle(); @(negedge clk);
    op_uncond = 1; dst_req = 1; #1;
    chk("R10 uncond pass", {31'h0, dst_we}, 32'h1);
    idle(); @(negedge clk);
    load(32'h01);
    op_cond = 1; dst_req = 1; #1;
    chk("R10 cond dc=1", {31'h0, dst_we}, 32'h1);
    chk("R10 dc out", {31'h0, dc}, 32'h1);
    idle(); @(negedge clk);

    rst_n = 0; #1;
    chk("R1 async clear", {24'h0, status}, 32'h0);
    @(negedge clk); rst_n = 1; @(negedge clk);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule